// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Latch

This block merges five reset sources into three domain resets. The sources are a power-on detect, an external active-low reset pin, an internal watchdog timeout, a GPIO-driven soft reset request and a sleep-exit event. A source asserts its domain resets at once, without waiting for a clock edge. It releases them on a clock edge, after a fixed stretch. Each source reaches a different set of domains:

| Source | Always-on domain (`aonRstN`) | System domain (`sysRstN`) | Sleep domain (`sleepDomRstN`) |
|---|---|---|---|
| Power-on or external pin | reset | reset | reset |
| Watchdog timeout | kept | reset | reset |
| GPIO soft reset | kept | reset | reset |
| Sleep exit | kept | kept | reset |

The always-on domain holds the cause latch, the watchdog enable, the watchdog timeout value and the real-time logic.

Boot code reads a four-bit sticky cause latch to decide between a full initialisation and a resume. A cause value of zero means no reset happened since software last cleared the bits. A small register window on a simple read/write bus gives access to four registers: the cause latch, a watchdog enable that can only be set, a watchdog restart/count register and a watchdog timeout value.

Top module: `reset_hub`

## Requirements
- R1: While `porDetect` is high or `extRstN` is low, all three domain resets are low. On release the cause register (address 0) reads 0x1: bit 0 (hardware) is set and bits 1 to 3 are clear. The enable register (address 1) reads 0 and the timeout register (address 3) reads the `DEF_TIMEOUT` parameter.
- R2: A domain reset goes high on the `HOLD_CYCLES`-th rising clock edge after its last active source drops. Each assertion lasts at least `HOLD_CYCLES` cycles.
- R3: Cause bits are sticky. Writing a 1 to a bit at address 0 clears that bit. Writing a 0 leaves the bit unchanged.
- R4: The watchdog starts disabled after a hardware reset. While bit 0 of address 1 is 0, no watchdog reset occurs, however long the count runs.
- R5: Once bit 0 of address 1 is set, writes cannot clear it. Only a hardware reset clears it.
- R6: When enabled, the watchdog fires after the number of cycles held at address 3. It resets the system and sleep domains, leaves the always-on domain running, and sets cause bit 1.
- R7: Any write to address 2 restarts the watchdog count from zero. A read of address 2 returns the current count.
- R8: A GPIO reset request resets the system and sleep domains but not the always-on domain. It sets cause bit 3 and leaves the other cause bits, the enable and the timeout value unchanged.
- R9: A sleep-exit event resets only the sleep domain and sets cause bit 2.
- R10: When several sources are active together, every one of their cause bits is set. Each domain stays in reset while any source that reaches it is active.
- R11: After all cause bits are cleared, address 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| porDetect | input | 1 | Power-on detect, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| gpioRstReq | input | 1 | GPIO soft reset request, active high, asynchronous |
| sleepExit | input | 1 | Sleep-exit event, active high, asynchronous |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address (0 cause, 1 enable, 2 restart/count, 3 timeout) |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| aonRstN | output | 1 | Always-on domain reset, active low |
| sysRstN | output | 1 | Core and peripheral domain reset, active low |
| sleepDomRstN | output | 1 | Sleep-powered domain reset, active low |

## Verification
The bench builds the block with `HOLD_CYCLES` = 5 and `DEF_TIMEOUT` = 200. The non-default stretch length shows that release timing follows the parameter and is not fixed at the minimum. The small default timeout lets the bench read the value back after a hardware reset, and lets it show that a disabled watchdog stays quiet well past that count. With a 40-cycle timeout written at run time, the bench observes the watchdog restart and fire, the GPIO reset preserving state, the sleep-exit reset and overlapping sources, all within a short run.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;

  // Reset source / cause bit positions (software decodes these)
  localparam int NUM_SRC    = 4;
  localparam int CAUSE_HW   = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int CAUSE_SLP  = 2;
  localparam int CAUSE_GPIO = 3;

  // Output domains
  localparam int NUM_DOM = 3;
  localparam int DOM_AON = 0;
  localparam int DOM_SYS = 1;
  localparam int DOM_SLP = 2;

  // Register addresses
  localparam int REG_CAUSE = 0;
  localparam int REG_WDCTL = 1;
  localparam int REG_WDCNT = 2;
  localparam int REG_LIMIT = 3;

  // Which sources reach which domain (bit i = cause bit i)
  function automatic logic [NUM_SRC-1:0] domScope(input int dom);
    logic [NUM_SRC-1:0] m;
    m = '0;
    m[CAUSE_HW] = 1'b1;
    if (dom != DOM_AON) begin
      m[CAUSE_WDOG] = 1'b1;
      m[CAUSE_GPIO] = 1'b1;
    end
    if (dom == DOM_SLP) m[CAUSE_SLP] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic [NUM_SRC-1:0] causeClr;
    logic               wdEnSet;
    logic               wdKick;
    logic               limitWr;
    logic               gpioEv;
    logic               sleepEv;
  } hubStrobe_t;

endpackage

// File: rtl/reset_hub_stretch.sv
module reset_hub_stretch #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic clearReq,
  output logic rstN
);
  localparam int LEN = (STAGES < 2) ? 2 : STAGES;

  logic [LEN-1:0] pipe;

  // Cleared at once, refilled one stage per rising edge
  always_ff @(posedge clk or posedge clearReq) begin
    if (clearReq) pipe <= '0;
    else          pipe <= {pipe[LEN-2:0], 1'b1};
  end

  assign rstN = pipe[LEN-1];

endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porDetect,
  input  logic               extRstN,
  input  logic               gpioRstReq,
  input  logic               sleepExit,
  input  logic               wdogFire,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] wrLow,
  output hubStrobe_t         strobe,
  output logic [NUM_DOM-1:0] domRstN
);
  localparam int SYNC_LEN = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic               hardReq;
  logic [NUM_SRC-1:0] srcReq;
  logic [NUM_DOM-1:0] domClear;
  logic [SYNC_LEN-1:0] gpioSync;
  logic [SYNC_LEN-1:0] sleepSync;
  logic               wrEn;

  assign hardReq = porDetect | ~extRstN;

  always_comb begin
    srcReq             = '0;
    srcReq[CAUSE_HW]   = hardReq;
    srcReq[CAUSE_WDOG] = wdogFire;
    srcReq[CAUSE_SLP]  = sleepExit;
    srcReq[CAUSE_GPIO] = gpioRstReq;
  end

  // One stretch chain per domain, each fed by its scope of sources
  for (genvar d = 0; d < NUM_DOM; d++) begin : gDom
    assign domClear[d] = |(srcReq & domScope(d));

    reset_hub_stretch #(.STAGES(HOLD_CYCLES)) uStretch (
      .clk     (clk),
      .clearReq(domClear[d]),
      .rstN    (domRstN[d])
    );

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (hardReq)
      $rose(domRstN[d]) |-> !domClear[d]); // R2
  end

  // Level synchronisers for the cause latch, living in the always-on domain
  always_ff @(posedge clk or negedge domRstN[DOM_AON]) begin
    if (!domRstN[DOM_AON]) begin
      gpioSync  <= '0;
      sleepSync <= '0;
    end else begin
      gpioSync  <= {gpioSync[SYNC_LEN-2:0], gpioRstReq};
      sleepSync <= {sleepSync[SYNC_LEN-2:0], sleepExit};
    end
  end

  // Bus decode into strobes
  assign wrEn = busSel & busWr;

  always_comb begin
    strobe          = '0;
    strobe.gpioEv   = gpioSync[SYNC_LEN-1];
    strobe.sleepEv  = sleepSync[SYNC_LEN-1];
    if (wrEn) begin
      if (busAddr == ADDR_W'(REG_CAUSE)) strobe.causeClr = wrLow;
      if (busAddr == ADDR_W'(REG_WDCTL)) strobe.wdEnSet  = wrLow[0];
      if (busAddr == ADDR_W'(REG_WDCNT)) strobe.wdKick   = 1'b1;
      if (busAddr == ADDR_W'(REG_LIMIT)) strobe.limitWr  = 1'b1;
    end
  end

  always_comb begin
    if (domRstN[DOM_AON] == 1'b0) begin
      AST_AON_COVERS_ALL: assert (domRstN == '0); // R1
    end
  end

  AST_AON_ONLY_HW: assert property (@(posedge clk) disable iff (hardReq)
    domRstN[DOM_AON] |=> domRstN[DOM_AON]); // R8

endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter int          ADDR_W      = 2,
  parameter int          DATA_W      = 32,
  parameter int unsigned DEF_TIMEOUT = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              aonRstN,
  input  hubStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              wdogFire
);
  logic [NUM_SRC-1:0] cause;
  logic [NUM_SRC-1:0] causeSet;
  logic               wdEn;
  logic [DATA_W-1:0]  wdCnt;
  logic [DATA_W-1:0]  wdLimit;
  logic               wdHit;

  always_comb begin
    causeSet             = '0;
    causeSet[CAUSE_WDOG] = wdogFire;
    causeSet[CAUSE_SLP]  = strobe.sleepEv;
    causeSet[CAUSE_GPIO] = strobe.gpioEv;
  end

  // Cause latch: a hardware reset leaves only the hardware bit set
  always_ff @(posedge clk or negedge aonRstN) begin
    if (!aonRstN) begin
      cause           <= '0;
      cause[CAUSE_HW] <= 1'b1;
    end else begin
      cause <= (cause & ~strobe.causeClr) | causeSet;
    end
  end

  // Watchdog enable is set-only
  always_ff @(posedge clk or negedge aonRstN) begin
    if (!aonRstN)            wdEn <= 1'b0;
    else if (strobe.wdEnSet) wdEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge aonRstN) begin
    if (!aonRstN)            wdLimit <= DATA_W'(DEF_TIMEOUT);
    else if (strobe.limitWr) wdLimit <= busWdata;
  end

  assign wdHit = (wdCnt == wdLimit - 1'b1);

  always_ff @(posedge clk or negedge aonRstN) begin
    if (!aonRstN) begin
      wdCnt    <= '0;
      wdogFire <= 1'b0;
    end else begin
      wdogFire <= wdEn && !strobe.wdKick && wdHit;
      if (!wdEn || strobe.wdKick || wdHit) wdCnt <= '0;
      else                                 wdCnt <= wdCnt + 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(REG_CAUSE): busRdata[NUM_SRC-1:0] = cause;
      ADDR_W'(REG_WDCTL): busRdata[0]           = wdEn;
      ADDR_W'(REG_WDCNT): busRdata              = wdCnt;
      ADDR_W'(REG_LIMIT): busRdata              = wdLimit;
      default:            busRdata              = '0;
    endcase
  end

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!aonRstN)
    !wdEn |=> !wdogFire); // R4
  AST_WDEN_STICKY: assert property (@(posedge clk) disable iff (!aonRstN)
    wdEn |=> wdEn); // R5
  AST_FIRE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!aonRstN)
    wdogFire |=> cause[CAUSE_WDOG]); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!aonRstN)
    strobe.causeClr[CAUSE_HW] |=> !cause[CAUSE_HW]); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!aonRstN)
    (cause[CAUSE_SLP] && !strobe.causeClr[CAUSE_SLP]) |=> cause[CAUSE_SLP]); // R3

endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int          ADDR_W      = 2,
  parameter int          DATA_W      = 32,
  parameter int          HOLD_CYCLES = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned DEF_TIMEOUT = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              porDetect,
  input  logic              extRstN,
  input  logic              gpioRstReq,
  input  logic              sleepExit,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              aonRstN,
  output logic              sysRstN,
  output logic              sleepDomRstN
);
  hubStrobe_t         strobe;
  logic [NUM_DOM-1:0] domRstN;
  logic               wdogFire;

  reset_hub_ctrl #(
    .ADDR_W     (ADDR_W),
    .HOLD_CYCLES(HOLD_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .porDetect (porDetect),
    .extRstN   (extRstN),
    .gpioRstReq(gpioRstReq),
    .sleepExit (sleepExit),
    .wdogFire  (wdogFire),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .wrLow     (busWdata[NUM_SRC-1:0]),
    .strobe    (strobe),
    .domRstN   (domRstN)
  );

  reset_hub_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DEF_TIMEOUT(DEF_TIMEOUT)
  ) uDp (
    .clk     (clk),
    .aonRstN (domRstN[DOM_AON]),
    .strobe  (strobe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .wdogFire(wdogFire)
  );

  assign aonRstN      = domRstN[DOM_AON];
  assign sysRstN      = domRstN[DOM_SYS];
  assign sleepDomRstN = domRstN[DOM_SLP];

endmodule

// File: tb/reset_hub_test.sv
`timescale 1ns/1ps
module reset_hub_test;
  localparam int HOLD = 5;
  localparam int TMO  = 200;

  logic        clk = 1'b0;
  logic        porDetect = 1'b1, extRstN = 1'b1, gpioRstReq = 1'b0, sleepExit = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        aonRstN, sysRstN, sleepDomRstN;

  reset_hub #(.ADDR_W(2), .DATA_W(32), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2),
              .DEF_TIMEOUT(TMO)) uut (
    .clk(clk), .porDetect(porDetect), .extRstN(extRstN), .gpioRstReq(gpioRstReq),
    .sleepExit(sleepExit), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .aonRstN(aonRstN), .sysRstN(sysRstN),
    .sleepDomRstN(sleepDomRstN));

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } expItem_t;
  expItem_t expQ[$];
  int nRun = 0, nFail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read per negedge
  always @(negedge clk) begin
    expItem_t it;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      check(it.tag, busRdata, it.exp);
    end
  end

  task automatic busRead(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    expQ.push_back('{e, tag});
    @(negedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk); v = busRdata; #1;
    busSel = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drop the hardware source at a negedge and time the release
  task automatic hwRelease(input string tag);
    int firstAon = 0, firstSys = 0, firstSlp = 0;
    @(negedge clk);
    porDetect = 1'b0; extRstN = 1'b1;
    for (int n = 1; n <= HOLD + 3; n++) begin
      @(negedge clk);
      if (aonRstN && firstAon == 0) firstAon = n;
      if (sysRstN && firstSys == 0) firstSys = n;
      if (sleepDomRstN && firstSlp == 0) firstSlp = n;
    end
    check({tag, " aon release"}, firstAon, HOLD);
    check({tag, " sys release"}, firstSys, HOLD);
    check({tag, " sleep release"}, firstSlp, HOLD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc, lowCnt;

    // R1: power-on holds every domain
    waitCyc(3);
    check("R1 por all low", {aonRstN, sysRstN, sleepDomRstN}, 3'b000);
    hwRelease("R2 por");
    busRead(0, 32'h1, "R1 cause after por");
    busRead(1, 32'h0, "R4 enable after por");
    busRead(3, TMO,   "R1 timeout default");

    // R3: write-zero keeps, write-one clears; R11 zero readback
    busWrite(0, 32'h0);
    busRead(0, 32'h1, "R3 write zero keeps");
    busWrite(0, 32'h1);
    busRead(0, 32'h0, "R11 cleared reads zero");

    // R4: disabled watchdog stays quiet past the default timeout
    lowCnt = 0;
    for (int n = 0; n < TMO + 50; n++) begin
      @(negedge clk);
      if (!sysRstN) lowCnt++;
    end
    check("R4 no fire while disabled", lowCnt, 0);
    busRead(2, 32'h0, "R4 count held at zero");

    // R5/R6/R7: enable, try to clear, restart, fire
    busWrite(3, 32'd40);
    busWrite(1, 32'h1);
    busRead(1, 32'h1, "R5 enable set");
    busWrite(1, 32'h0);
    busRead(1, 32'h1, "R5 enable survives write zero");
    waitCyc(15);
    busWrite(2, 32'h0);
    peek(2, v);
    check("R7 restart count small", (v <= 2), 1'b1);
    cyc = 0; lowCnt = 0;
    for (int n = 1; n <= 60 && cyc == 0; n++) begin
      @(negedge clk);
      if (!aonRstN) lowCnt++;
      if (!sysRstN) cyc = n;
    end
    check("R6 fire window", (cyc >= 34 && cyc <= 42), 1'b1);
    check("R6 sleep domain reset too", sleepDomRstN, 1'b0);
    check("R6 aon untouched", lowCnt, 0);
    lowCnt = 1;
    while (!sysRstN && lowCnt < 50) begin
      @(negedge clk);
      if (!sysRstN) lowCnt++;
    end
    check("R2 wdog hold length", (lowCnt >= HOLD), 1'b1);
    busRead(0, 32'h2, "R6 cause wdog bit");

    // R1: external pin clears cause, enable, timeout
    @(negedge clk); extRstN = 1'b0;
    #1 check("R1 pin all low", {aonRstN, sysRstN, sleepDomRstN}, 3'b000);
    waitCyc(3);
    hwRelease("R2 pin");
    busRead(0, 32'h1, "R1 cause after pin");
    busRead(1, 32'h0, "R1 enable cleared by pin");
    busRead(3, TMO,   "R1 timeout restored");

    // R8: GPIO soft reset
    busWrite(0, 32'hF);
    busWrite(3, 32'd77);
    @(negedge clk); gpioRstReq = 1'b1;
    #1 check("R8 gpio domains", {aonRstN, sysRstN, sleepDomRstN}, 3'b100);
    waitCyc(3);
    @(negedge clk); gpioRstReq = 1'b0;
    waitCyc(HOLD + 3);
    check("R8 sys released", sysRstN, 1'b1);
    busRead(0, 32'h8,   "R8 cause gpio bit");
    busRead(3, 32'd77,  "R8 timeout preserved");
    busRead(1, 32'h0,   "R8 enable preserved");

    // R9: sleep exit
    busWrite(0, 32'hF);
    @(negedge clk); sleepExit = 1'b1;
    #1 check("R9 sleep domains", {aonRstN, sysRstN, sleepDomRstN}, 3'b110);
    waitCyc(3);
    @(negedge clk); sleepExit = 1'b0;
    waitCyc(HOLD + 3);
    busRead(0, 32'h4, "R9 cause sleep bit");

    // R10: gpio and sleep together
    busWrite(0, 32'hF);
    @(negedge clk); gpioRstReq = 1'b1; sleepExit = 1'b1;
    waitCyc(4);
    @(negedge clk); gpioRstReq = 1'b0; sleepExit = 1'b0;
    waitCyc(HOLD + 3);
    busRead(0, 32'hC, "R10 both cause bits");

    // R10: pin and gpio overlap, gpio outlasts pin
    @(negedge clk); extRstN = 1'b0; gpioRstReq = 1'b1;
    waitCyc(3);
    @(negedge clk); extRstN = 1'b1;
    waitCyc(HOLD + 2);
    check("R10 widest scope split", {aonRstN, sysRstN}, 2'b10);
    @(negedge clk); gpioRstReq = 1'b0;
    waitCyc(HOLD + 3);
    busRead(0, 32'h9, "R10 hw and gpio bits");
    busWrite(0, 32'hF);
    busRead(0, 32'h0, "R11 all clear");

    waitCyc(2);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule